// File: doc/BRIEF.md
# Three-Wire Control Word Decoder

This block is the control port a host microcontroller uses to configure an audio processing chain. The host drives three wires: a shift clock, a serial data line and a latch strobe. Each control word is 24 bits long, and bit D00 arrives first. When the latch line rises, the last 24 bits shifted in are decoded as one word. The top bits of the word select one of four targets: attenuator level, operating mode, filter/effect settings, or a write into a 32-entry coefficient store.

All three wires are asynchronous to the system clock. Each wire passes through a two-flop synchronizer, and edges are detected in the system clock domain. A decoded register changes in the same system-clock cycle as a one-cycle strobe for its group. This lets the downstream effect logic reload its settings exactly once per accepted word.

A parameter mask marks some store addresses as offset entries. An offset entry keeps only the upper 10 of its 18 data bits, and its lower 8 bits are stored as zero. Every other address stores the full 18-bit word. The store has a registered read port so the consuming logic, or a test, can fetch entries.

Top module: `ctlw_decoder`

## Requirements
- R1: On each rising edge of the shift clock, one data bit is captured. The 24 bits captured last before the latch rises form the word, with the first of them as bit 0. Any bits captured before those 24 are dropped.
- R2: A word with bits 23 and 22 both 0 is an attenuator word, and `attn_o` takes bits 21..15.
- R3: A word with bits 23..21 equal to 010 is a mode word. It loads `mono_o` from bit 17, `chsel_o` from bit 16 and `wlen_o` from bits 15..14.
- R4: Bits 20..18 of a mode word select the program, shown on `prog_o`:
  - code 000 gives 0 (full chain, normal speed);
  - code 011 gives 1 (filter only, normal speed);
  - code 101 gives 2 (filter only, double speed).
  Any other code leaves `prog_o` unchanged, and `prog_o` never shows 3.
- R5: A word with bits 23..21 equal to 011 is a filter word. It loads these outputs:
  - `dyn_sel_o` from bits 20..19;
  - `deci_o` from bits 18..17;
  - `fbk_o` from bits 16..15;
  - `wide_o` from bits 14..13;
  - `osf_o` from bits 12..11;
  - `emph_o` from bits 10..9;
  - `rel_long_o` from bit 8, `att_long_o` from bit 7 and `gain_hi_o` from bit 6.
- R6: A word with bit 23 set writes bits 17..0 into the store, at the address in bits 22..18. For addresses not in the offset mask, all 18 bits are stored.
- R7: For an address in the offset mask (default 0x10..0x15), the stored value is bits 17..8 of the word followed by eight zero bits.
- R8: A decoded register updates on the third system-clock edge after the latch input rises. On that same edge exactly one group strobe rises, and it stays high for one cycle. No strobe pulses at any other time.
- R9: After reset:
  - `attn_o` is 0 and `prog_o` is 0;
  - all mode and filter outputs are 0;
  - all strobes are low.
- R10: A word for one group leaves the registers of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_clk_i | input | 1 | Serial shift clock from the host (asynchronous) |
| ctl_dat_i | input | 1 | Serial data from the host, bit 0 first |
| ctl_lat_i | input | 1 | Latch strobe; its rising edge applies the word |
| attn_o | output | 7 | Attenuator level |
| attn_stb_o | output | 1 | One-cycle pulse when `attn_o` is reloaded |
| prog_o | output | 2 | Program select (0 full, 1 filter only, 2 double speed) |
| mono_o | output | 1 | Monaural enable |
| chsel_o | output | 1 | Monaural channel pick |
| wlen_o | output | 2 | Input word length code |
| mode_stb_o | output | 1 | One-cycle pulse on a mode word |
| dyn_sel_o | output | 2 | Compressor / bass boost select |
| deci_o | output | 2 | Decimation select |
| fbk_o | output | 2 | Feedback filter select |
| wide_o | output | 2 | Stereo widening select |
| osf_o | output | 2 | Oversampling filter select |
| emph_o | output | 2 | De-emphasis select |
| rel_long_o | output | 1 | Long release time |
| att_long_o | output | 1 | Long attack time |
| gain_hi_o | output | 1 | Large effect gain |
| filt_stb_o | output | 1 | One-cycle pulse on a filter word |
| coef_stb_o | output | 1 | One-cycle pulse on a store write |
| coef_raddr_i | input | 5 | Store read address |
| coef_rdata_o | output | 18 | Store read data, one cycle after the address |

## Verification
Attenuator values at both ends of the range and one mid-range value show whether the field is sliced at the right bit positions. Mode words cycle through all three legal program codes and then an illegal one. This separates a decoder that holds the program on an unknown code from one that resets it, and it also shows the other mode fields still update. Two filter words with complementary alternating patterns catch swapped or shifted fields. Store writes to plain and offset addresses, each read back, separate full-width storage from truncation. A word preceded by six extra junk bits shows that only the last 24 bits count.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 18;
  localparam int KEEP_W = 10;
  localparam int ATTN_W = 7;

  typedef enum logic [1:0] {
    PRG_FULL = 2'd0,
    PRG_FILT = 2'd1,
    PRG_DBL  = 2'd2
  } prog_e;
endpackage

// File: rtl/ctlw_sync.sv
module ctlw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/ctlw_shift.sv
module ctlw_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)       word_o <= '0;
    else if (en_i) word_o <= {bit_i, word_o[W-1:1]};
  end
endmodule

// File: rtl/ctlw_coef_mem.sv
module ctlw_coef_mem #(
  parameter int AW = 5,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ctlw_decoder.sv
module ctlw_decoder
  import ctlw_pkg::*;
#(
  parameter int          AW       = ADDR_W,
  parameter int          DW       = DATA_W,
  parameter int          KW       = KEEP_W,
  parameter logic [31:0] OFS_MASK = 32'h003F_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_clk_i,
  input  logic          ctl_dat_i,
  input  logic          ctl_lat_i,
  output logic [6:0]    attn_o,
  output logic          attn_stb_o,
  output logic [1:0]    prog_o,
  output logic          mono_o,
  output logic          chsel_o,
  output logic [1:0]    wlen_o,
  output logic          mode_stb_o,
  output logic [1:0]    dyn_sel_o,
  output logic [1:0]    deci_o,
  output logic [1:0]    fbk_o,
  output logic [1:0]    wide_o,
  output logic [1:0]    osf_o,
  output logic [1:0]    emph_o,
  output logic          rel_long_o,
  output logic          att_long_o,
  output logic          gain_hi_o,
  output logic          filt_stb_o,
  output logic          coef_stb_o,
  input  logic [4:0]    coef_raddr_i,
  output logic [17:0]   coef_rdata_o
);
  localparam int WW    = 1 + AW + DW;
  localparam int DROPW = DW - KW;

  logic [2:0]    sync_q;
  logic          clk_d, lat_d;
  logic          clk_rise, lat_rise;
  logic [WW-1:0] word;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  prog_e         prog_q;

  ctlw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ctl_lat_i, ctl_dat_i, ctl_clk_i}),
    .q_o (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      lat_d <= 1'b0;
    end else begin
      clk_d <= sync_q[0];
      lat_d <= sync_q[2];
    end
  end

  assign clk_rise = sync_q[0] & ~clk_d;
  assign lat_rise = sync_q[2] & ~lat_d;

  ctlw_shift #(.W(WW)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .en_i   (clk_rise),
    .bit_i  (sync_q[1]),
    .word_o (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      attn_o     <= '0;
      prog_q     <= PRG_FULL;
      mono_o     <= 1'b0;
      chsel_o    <= 1'b0;
      wlen_o     <= '0;
      dyn_sel_o  <= '0;
      deci_o     <= '0;
      fbk_o      <= '0;
      wide_o     <= '0;
      osf_o      <= '0;
      emph_o     <= '0;
      rel_long_o <= 1'b0;
      att_long_o <= 1'b0;
      gain_hi_o  <= 1'b0;
      attn_stb_o <= 1'b0;
      mode_stb_o <= 1'b0;
      filt_stb_o <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      attn_stb_o <= 1'b0;
      mode_stb_o <= 1'b0;
      filt_stb_o <= 1'b0;
      mem_we     <= 1'b0;
      if (lat_rise) begin
        if (word[WW-1]) begin
          mem_we   <= 1'b1;
          mem_addr <= word[DW +: AW];
          if (OFS_MASK[word[DW +: AW]])
            mem_wdata <= {word[DW-1 -: KW], {DROPW{1'b0}}};
          else
            mem_wdata <= word[DW-1:0];
        end else if (!word[22]) begin
          attn_o     <= word[21:15];
          attn_stb_o <= 1'b1;
        end else if (!word[21]) begin
          unique case (word[20:18])
            3'b000:  prog_q <= PRG_FULL;
            3'b011:  prog_q <= PRG_FILT;
            3'b101:  prog_q <= PRG_DBL;
            default: prog_q <= prog_q;
          endcase
          mono_o     <= word[17];
          chsel_o    <= word[16];
          wlen_o     <= word[15:14];
          mode_stb_o <= 1'b1;
        end else begin
          dyn_sel_o  <= word[20:19];
          deci_o     <= word[18:17];
          fbk_o      <= word[16:15];
          wide_o     <= word[14:13];
          osf_o      <= word[12:11];
          emph_o     <= word[10:9];
          rel_long_o <= word[8];
          att_long_o <= word[7];
          gain_hi_o  <= word[6];
          filt_stb_o <= 1'b1;
        end
      end
    end
  end

  assign prog_o     = prog_q;
  assign coef_stb_o = mem_we;

  ctlw_coef_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_addr),
    .wdata_i (mem_wdata),
    .raddr_i (coef_raddr_i),
    .rdata_o (coef_rdata_o)
  );
endmodule

// File: rtl/ctlw_decoder_chk.sv
module ctlw_decoder_chk #(
  parameter int          AW       = 5,
  parameter int          DW       = 18,
  parameter logic [31:0] OFS_MASK = 32'h003F_0000
) (
  input logic          clk,
  input logic          rst,
  input logic [6:0]    attn_o,
  input logic [1:0]    prog_o,
  input logic [17:0]   filt_v,
  input logic          attn_stb_o,
  input logic          mode_stb_o,
  input logic          filt_stb_o,
  input logic          coef_stb_o,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({attn_stb_o, mode_stb_o, filt_stb_o, coef_stb_o}));

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (attn_stb_o | mode_stb_o | filt_stb_o | coef_stb_o) |=>
      !(attn_stb_o | mode_stb_o | filt_stb_o | coef_stb_o));

  // R2
  attn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(attn_o) |-> attn_stb_o);

  // R4
  prog_legal_chk: assert property (@(posedge clk) disable iff (rst)
    prog_o != 2'd3);

  // R4
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(prog_o) |-> mode_stb_o);

  // R5
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_v) |-> filt_stb_o);

  // R7
  ofs_trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && OFS_MASK[mem_addr]) |-> (mem_wdata[7:0] == 8'h00));
endmodule

bind ctlw_decoder ctlw_decoder_chk #(.AW(AW), .DW(DW), .OFS_MASK(OFS_MASK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .attn_o     (attn_o),
  .prog_o     (prog_o),
  .filt_v     ({dyn_sel_o, deci_o, fbk_o, wide_o, osf_o, emph_o,
                rel_long_o, att_long_o, gain_hi_o}),
  .attn_stb_o (attn_stb_o),
  .mode_stb_o (mode_stb_o),
  .filt_stb_o (filt_stb_o),
  .coef_stb_o (coef_stb_o),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/sim_ctlw_decoder.sv
`timescale 1ns/1ps
module sim_ctlw_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, slat = 1'b0;
  logic [4:0]  raddr = '0;
  logic [6:0]  attn;
  logic [1:0]  prog, wlen, dyn, deci, fbk, wide, osf, emph;
  logic        mono, chsel, rel_l, att_l, gain_h;
  logic        s_attn, s_mode, s_filt, s_coef;
  logic [17:0] rdata;

  always #5 clk = ~clk;

  ctlw_decoder u0 (
    .clk(clk), .rst(rst), .ctl_clk_i(sclk), .ctl_dat_i(sdat), .ctl_lat_i(slat),
    .attn_o(attn), .attn_stb_o(s_attn), .prog_o(prog), .mono_o(mono),
    .chsel_o(chsel), .wlen_o(wlen), .mode_stb_o(s_mode), .dyn_sel_o(dyn),
    .deci_o(deci), .fbk_o(fbk), .wide_o(wide), .osf_o(osf), .emph_o(emph),
    .rel_long_o(rel_l), .att_long_o(att_l), .gain_hi_o(gain_h),
    .filt_stb_o(s_filt), .coef_stb_o(s_coef), .coef_raddr_i(raddr),
    .coef_rdata_o(rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;

  // reference state
  int e_attn = 0, e_prog = 0, e_mono = 0, e_chs = 0, e_wlen = 0;
  int e_filt = 0;
  int e_stb = 0;
  int ref_mem [32];

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 attn", int'(attn), e_attn);
      check("R4 prog", int'(prog), e_prog);
      check("R3 mono", int'(mono), e_mono);
      check("R3 chsel", int'(chsel), e_chs);
      check("R3 wlen", int'(wlen), e_wlen);
      check("R5 filter fields", int'({dyn, deci, fbk, wide, osf, emph, rel_l, att_l, gain_h}), e_filt);
      check("R8 strobes", int'({s_coef, s_filt, s_mode, s_attn}), e_stb);
    end
  end

  function automatic bit is_ofs(input int a);
    return (a >= 16) && (a <= 21);
  endfunction

  // behavioural reference decode of one 24-bit word
  task automatic ref_apply(input logic [23:0] w);
    int top3;
    top3 = (w >> 21) & 7;
    if (top3 >= 4) begin
      int a, d;
      a = (w >> 18) & 31;
      d = w & 18'h3FFFF;
      if (is_ofs(a)) d = (d / 256) * 256;
      ref_mem[a] = d;
      e_stb = 8;
    end else if (top3 < 2) begin
      e_attn = (w >> 15) & 127;
      e_stb = 1;
    end else if (top3 == 2) begin
      int ps;
      ps = (w >> 18) & 7;
      if (ps == 0) e_prog = 0;
      else if (ps == 3) e_prog = 1;
      else if (ps == 5) e_prog = 2;
      e_mono = (w >> 17) & 1;
      e_chs  = (w >> 16) & 1;
      e_wlen = (w >> 14) & 3;
      e_stb = 2;
    end else begin
      e_filt = (w >> 6) & 18'h7FFF;
      e_stb = 4;
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); sdat = b; sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
  endtask

  // pre: number of junk bits sent before the word (R1)
  task automatic send(input logic [23:0] w, input int pre);
    for (int i = 0; i < pre; i++) put_bit(1'b1);
    for (int i = 0; i < 24; i++) put_bit(w[i]);
    repeat (4) @(negedge clk);
    slat = 1'b1;
    repeat (3) @(posedge clk);
    ref_apply(w);
    @(posedge clk);
    e_stb = 0;
    repeat (3) @(negedge clk);
    slat = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic read_chk(input int a, input string tag);
    @(negedge clk); raddr = a[4:0];
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(rdata), ref_mem[a]);
  endtask

  function automatic logic [23:0] w_attn(input logic [6:0] a);
    return {2'b00, a, 15'h0};
  endfunction
  function automatic logic [23:0] w_mode(input logic [2:0] ps, input logic mo,
                                         input logic ch, input logic [1:0] wl);
    return {3'b010, ps, mo, ch, wl, 14'h0};
  endfunction
  function automatic logic [23:0] w_filt(input logic [14:0] f);
    return {3'b011, f, 6'h0};
  endfunction
  function automatic logic [23:0] w_ram(input logic [4:0] a, input logic [17:0] d);
    return {1'b1, a, d};
  endfunction

  task automatic run_all();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 reset attn", int'(attn), 0);
    check("R9 reset prog", int'(prog), 0);
    check("R9 reset strobes", int'({s_coef, s_filt, s_mode, s_attn}), 0);
    cmp_on = 1;
    // R2 attenuator range, R10 others untouched (per-clock compare)
    send(w_attn(7'h7F), 0);
    check("R2 attn max", int'(attn), 127);
    send(w_attn(7'h00), 0);
    send(w_attn(7'h2A), 0);
    check("R2 attn mid", int'(attn), 42);
    // R3 / R4 program codes
    send(w_mode(3'b011, 1'b1, 1'b0, 2'b11), 0);
    check("R4 prog filter only", int'(prog), 1);
    send(w_mode(3'b101, 1'b0, 1'b1, 2'b01), 0);
    check("R4 prog double", int'(prog), 2);
    send(w_mode(3'b110, 1'b1, 1'b1, 2'b10), 0);
    check("R4 illegal code holds prog", int'(prog), 2);
    check("R3 mono after illegal code", int'(mono), 1);
    send(w_mode(3'b000, 1'b0, 1'b0, 2'b00), 0);
    check("R4 prog full", int'(prog), 0);
    // R5 filter fields, complementary patterns
    send(w_filt(15'h5555), 0);
    check("R5 filter pattern a", int'({dyn, deci, fbk, wide, osf, emph, rel_l, att_l, gain_h}), 15'h5555);
    send(w_filt(15'h2AAA), 0);
    // R6 / R7 store writes
    send(w_ram(5'd3, 18'h2ABCD), 0);
    send(w_ram(5'h12, 18'h3FFFF), 0);
    send(w_ram(5'h1F, 18'h00001), 0);
    send(w_ram(5'h10, 18'h155AA), 0);
    send(w_ram(5'h16, 18'h000FF), 0);
    read_chk(3, "R6 plain addr 3");
    read_chk(31, "R6 plain addr 31");
    read_chk(22, "R6 plain addr 22 past offset range");
    read_chk(18, "R7 offset addr 18");
    read_chk(16, "R7 offset addr 16");
    check("R7 offset low byte zero", int'(rdata) & 255, 0);
    // R1 junk bits ahead of the word
    send(w_attn(7'h55), 6);
    check("R1 last 24 bits", int'(attn), 7'h55);
    send(w_ram(5'd7, 18'h1F00F), 5);
    read_chk(7, "R1 R6 junk-prefixed write");
    repeat (10) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule